// File: doc/BRIEF.md
# Audio DMA Request Channel Sequencer

This block paces byte-wide DMA transfers for a full-duplex audio port that has a playback path and a capture path. When a path needs a new sample and its enable bit is set, the block raises a DMA request. It counts the byte transfers that the host completes: each one is an acknowledge qualified by a write strobe for playback or a read strobe for capture. The sample format sets how many bytes make up one sample. A lane code tells the datapath which half of which channel the current byte belongs to. When the final byte lands, the request drops and a one-cycle done pulse goes to the path that owns the sample.

A mode input selects the channel arrangement. With two channels, playback uses request/acknowledge pair A and capture uses pair B, and both can run at the same time. With one shared channel, both directions use pair A and the sequencer allows one sample at a time. The direction is chosen only by the two enable bits, and playback wins when both are ready. No reconfiguration state is ever entered. The mode input is expected to change only while both paths are idle.

Top module: `audio_dma_seq`

## Requirements
- R1: After a synchronous reset, both request outputs, both done pulses and both lane codes are 0.
- R2: With `single_chan`=0, playback requests on `req_a` and advances on `ack_a` with `wr_stb`. Capture requests on `req_b` and advances on `ack_b` with `rd_stb`. The two paths run independently and may transfer in the same cycle.
- R3: With `single_chan`=1, both directions request on `req_a` and advance only on `ack_a`, with `wr_stb` for playback or `rd_stb` for capture. `req_b` stays 0, `ack_b` has no effect, and at most one direction holds a request.
- R4: With `single_chan`=1, if both paths are enabled and need a sample while both are idle, the playback sample is served first. Capture starts only after playback's sample has finished.
- R5: A path starts a sample only while its enable bit is 1. Clearing the enable during a sample does not cut that sample short.
- R6: Bytes per sample, with `fmt_wide` (1 = 16-bit) and `fmt_stereo` (1 = stereo): 8-bit mono 1, 8-bit stereo 2, 16-bit mono 2, 16-bit stereo 4.
- R7: The lane code is {right channel, high byte}. The lanes go in this order. 8-bit mono: 00. 8-bit stereo: 00 then 10. 16-bit mono: 00 then 01. 16-bit stereo: 00, 01, 10, 11. The code changes only on a counted transfer.
- R8: A request stays high until its final byte is transferred. An acknowledge without the matching strobe, or a strobe without the acknowledge, does not advance the byte count.
- R9: After the final byte, the request is low for at least one clock before it can rise again.
- R10: The path's done output is high for exactly one cycle: the cycle after the edge at which the final byte was transferred.
- R11: The format inputs are captured when a sample starts. Changing them during a sample does not alter that sample's byte count or lane order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| single_chan | input | 1 | 1 = one shared DMA channel, 0 = separate channels |
| play_en | input | 1 | Playback enable |
| cap_en | input | 1 | Capture enable |
| fmt_stereo | input | 1 | 1 = stereo samples |
| fmt_wide | input | 1 | 1 = 16-bit samples |
| play_need | input | 1 | Playback path wants a sample |
| cap_need | input | 1 | Capture path has a sample to deliver |
| ack_a | input | 1 | DMA acknowledge, channel A |
| ack_b | input | 1 | DMA acknowledge, channel B |
| rd_stb | input | 1 | Host read strobe (capture byte) |
| wr_stb | input | 1 | Host write strobe (playback byte) |
| req_a | output | 1 | DMA request, channel A |
| req_b | output | 1 | DMA request, channel B |
| play_done | output | 1 | One-cycle pulse: playback sample complete |
| cap_done | output | 1 | One-cycle pulse: capture sample complete |
| play_lane | output | 2 | Playback byte lane {right, high} |
| cap_lane | output | 2 | Capture byte lane {right, high} |

## Verification
The assertions check on every cycle the rules that hold cycle by cycle:
- requests held until completion
- the gap after a request falls
- single-cycle done pulses that follow a counted transfer
- lanes that stay put without a transfer
- no start while disabled
- mutual exclusion and playback priority on the shared channel

The byte count and lane order for each format, the latching of the format at sample start, the concurrency of the two channels and the immunity to stray strobes depend on particular stimulus sequences. Only the bench scenarios show those.

// File: rtl/adq_pkg.sv
package adq_pkg;

  localparam int NUM_PATHS = 2;
  localparam int IDX_W     = 2;
  localparam int LANE_W    = 2;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_BUSY = 2'd1,
    SQ_GAP  = 2'd2
  } sq_state_t;

  function automatic logic [IDX_W-1:0] final_index(input logic stereo, input logic wide);
    logic [IDX_W-1:0] r;
    case ({wide, stereo})
      2'b00:   r = IDX_W'(0);
      2'b01:   r = IDX_W'(1);
      2'b10:   r = IDX_W'(1);
      default: r = IDX_W'(3);
    endcase
    return r;
  endfunction

  function automatic logic [LANE_W-1:0] lane_code(input logic [IDX_W-1:0] idx,
                                                  input logic stereo, input logic wide);
    logic [LANE_W-1:0] r;
    case ({wide, stereo})
      2'b11:   r = idx;
      2'b10:   r = {1'b0, idx[0]};
      2'b01:   r = {idx[0], 1'b0};
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/adq_beat_seq.sv
module adq_beat_seq
  import adq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              need,
  input  logic              grant,
  input  logic              fmt_stereo,
  input  logic              fmt_wide,
  input  logic              xfer,
  output logic              req,
  output logic              done,
  output logic [LANE_W-1:0] lane,
  output logic              busy
);

  sq_state_t        state;
  logic [IDX_W-1:0] idx;
  logic             stereo_q;
  logic             wide_q;
  logic [IDX_W-1:0] idx_nx;

  assign idx_nx = idx + IDX_W'(1);
  assign busy   = (state != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      idx      <= '0;
      stereo_q <= 1'b0;
      wide_q   <= 1'b0;
      req      <= 1'b0;
      done     <= 1'b0;
      lane     <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (en && need && grant) begin
            state    <= SQ_BUSY;
            req      <= 1'b1;
            idx      <= '0;
            lane     <= '0;
            stereo_q <= fmt_stereo;
            wide_q   <= fmt_wide;
          end
        end
        SQ_BUSY: begin
          if (xfer) begin
            if (idx == final_index(stereo_q, wide_q)) begin
              state <= SQ_GAP;
              req   <= 1'b0;
              done  <= 1'b1;
              idx   <= '0;
              lane  <= '0;
            end else begin
              idx  <= idx_nx;
              lane <= lane_code(idx_nx, stereo_q, wide_q);
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adq_router.sv
module adq_router (
  input  logic single_chan,
  input  logic play_en,
  input  logic play_need,
  input  logic play_busy,
  input  logic cap_busy,
  input  logic play_req,
  input  logic cap_req,
  input  logic ack_a,
  input  logic ack_b,
  input  logic rd_stb,
  input  logic wr_stb,
  output logic play_grant,
  output logic cap_grant,
  output logic play_xfer,
  output logic cap_xfer,
  output logic req_a,
  output logic req_b
);

  logic cap_ack;

  assign cap_ack    = single_chan ? ack_a : ack_b;
  assign play_xfer  = play_req & ack_a & wr_stb;
  assign cap_xfer   = cap_req & cap_ack & rd_stb;

  assign play_grant = ~single_chan | ~cap_busy;
  assign cap_grant  = ~single_chan | (~play_busy & ~(play_en & play_need));

  assign req_a      = play_req | (single_chan & cap_req);
  assign req_b      = ~single_chan & cap_req;

endmodule

// File: rtl/audio_dma_seq.sv
module audio_dma_seq
  import adq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              single_chan,
  input  logic              play_en,
  input  logic              cap_en,
  input  logic              fmt_stereo,
  input  logic              fmt_wide,
  input  logic              play_need,
  input  logic              cap_need,
  input  logic              ack_a,
  input  logic              ack_b,
  input  logic              rd_stb,
  input  logic              wr_stb,
  output logic              req_a,
  output logic              req_b,
  output logic              play_done,
  output logic              cap_done,
  output logic [LANE_W-1:0] play_lane,
  output logic [LANE_W-1:0] cap_lane
);

  logic [NUM_PATHS-1:0] en_v;
  logic [NUM_PATHS-1:0] need_v;
  logic [NUM_PATHS-1:0] grant_v;
  logic [NUM_PATHS-1:0] xfer_v;
  logic [NUM_PATHS-1:0] req_v;
  logic [NUM_PATHS-1:0] done_v;
  logic [NUM_PATHS-1:0] busy_v;
  logic [LANE_W-1:0]    lane_v [NUM_PATHS];

  logic play_req_i, cap_req_i, play_xfer_i, cap_xfer_i;

  assign en_v   = {cap_en, play_en};
  assign need_v = {cap_need, play_need};

  for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
    adq_beat_seq u_seq (
      .clk        (clk),
      .rst        (rst),
      .en         (en_v[g]),
      .need       (need_v[g]),
      .grant      (grant_v[g]),
      .fmt_stereo (fmt_stereo),
      .fmt_wide   (fmt_wide),
      .xfer       (xfer_v[g]),
      .req        (req_v[g]),
      .done       (done_v[g]),
      .lane       (lane_v[g]),
      .busy       (busy_v[g])
    );
  end

  adq_router u_route (
    .single_chan (single_chan),
    .play_en     (play_en),
    .play_need   (play_need),
    .play_busy   (busy_v[0]),
    .cap_busy    (busy_v[1]),
    .play_req    (req_v[0]),
    .cap_req     (req_v[1]),
    .ack_a       (ack_a),
    .ack_b       (ack_b),
    .rd_stb      (rd_stb),
    .wr_stb      (wr_stb),
    .play_grant  (grant_v[0]),
    .cap_grant   (grant_v[1]),
    .play_xfer   (xfer_v[0]),
    .cap_xfer    (xfer_v[1]),
    .req_a       (req_a),
    .req_b       (req_b)
  );

  assign play_req_i  = req_v[0];
  assign cap_req_i   = req_v[1];
  assign play_xfer_i = xfer_v[0];
  assign cap_xfer_i  = xfer_v[1];

  assign play_done = done_v[0];
  assign cap_done  = done_v[1];
  assign play_lane = lane_v[0];
  assign cap_lane  = lane_v[1];

endmodule

// File: rtl/adq_checker.sv
module adq_checker (
  input logic       clk,
  input logic       rst,
  input logic       single_chan,
  input logic       play_en,
  input logic       cap_en,
  input logic       play_need,
  input logic       play_done,
  input logic       cap_done,
  input logic [1:0] play_lane,
  input logic [1:0] cap_lane,
  input logic       play_req_i,
  input logic       cap_req_i,
  input logic       play_xfer_i,
  input logic       cap_xfer_i
);

  AST_SHARED_EXCL: assert property (@(posedge clk) disable iff (rst)
    single_chan |-> !(play_req_i && cap_req_i)); // R3

  AST_PRIO_PLAY: assert property (@(posedge clk) disable iff (rst)
    single_chan && !play_req_i && !cap_req_i && play_en && play_need |=> !cap_req_i); // R4

  AST_NO_START_PLAY: assert property (@(posedge clk) disable iff (rst)
    !play_en && !play_req_i |=> !play_req_i); // R5

  AST_NO_START_CAP: assert property (@(posedge clk) disable iff (rst)
    !cap_en && !cap_req_i |=> !cap_req_i); // R5

  AST_LANE_HOLD_PLAY: assert property (@(posedge clk) disable iff (rst)
    play_req_i && !play_xfer_i |=> $stable(play_lane)); // R7

  AST_LANE_HOLD_CAP: assert property (@(posedge clk) disable iff (rst)
    cap_req_i && !cap_xfer_i |=> $stable(cap_lane)); // R7

  AST_REQ_HOLD_PLAY: assert property (@(posedge clk) disable iff (rst)
    play_req_i |=> play_req_i || play_done); // R8

  AST_REQ_HOLD_CAP: assert property (@(posedge clk) disable iff (rst)
    cap_req_i |=> cap_req_i || cap_done); // R8

  AST_GAP_PLAY: assert property (@(posedge clk) disable iff (rst)
    $fell(play_req_i) |=> !play_req_i); // R9

  AST_GAP_CAP: assert property (@(posedge clk) disable iff (rst)
    $fell(cap_req_i) |=> !cap_req_i); // R9

  AST_DONE_PULSE_PLAY: assert property (@(posedge clk) disable iff (rst)
    play_done |=> !play_done); // R10

  AST_DONE_PULSE_CAP: assert property (@(posedge clk) disable iff (rst)
    cap_done |=> !cap_done); // R10

  AST_DONE_CAUSE_PLAY: assert property (@(posedge clk) disable iff (rst)
    play_done |-> $past(play_xfer_i)); // R10

  AST_DONE_CAUSE_CAP: assert property (@(posedge clk) disable iff (rst)
    cap_done |-> $past(cap_xfer_i)); // R10

endmodule

bind audio_dma_seq adq_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .single_chan (single_chan),
  .play_en     (play_en),
  .cap_en      (cap_en),
  .play_need   (play_need),
  .play_done   (play_done),
  .cap_done    (cap_done),
  .play_lane   (play_lane),
  .cap_lane    (cap_lane),
  .play_req_i  (play_req_i),
  .cap_req_i   (cap_req_i),
  .play_xfer_i (play_xfer_i),
  .cap_xfer_i  (cap_xfer_i)
);

// File: tb/sim_audio_dma_seq.sv
module sim_audio_dma_seq;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic single_chan = 1'b0, play_en = 1'b0, cap_en = 1'b0;
  logic fmt_stereo = 1'b0, fmt_wide = 1'b0;
  logic play_need = 1'b0, cap_need = 1'b0;
  logic ack_a = 1'b0, ack_b = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic req_a, req_b, play_done, cap_done;
  logic [1:0] play_lane, cap_lane;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  audio_dma_seq u0 (
    .clk(clk), .rst(rst), .single_chan(single_chan), .play_en(play_en), .cap_en(cap_en),
    .fmt_stereo(fmt_stereo), .fmt_wide(fmt_wide), .play_need(play_need), .cap_need(cap_need),
    .ack_a(ack_a), .ack_b(ack_b), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .req_a(req_a), .req_b(req_b), .play_done(play_done), .cap_done(cap_done),
    .play_lane(play_lane), .cap_lane(cap_lane)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic st, input logic wd);
    if (wd && st) return 4;
    if (wd || st) return 2;
    return 1;
  endfunction

  function automatic logic [1:0] exp_lane(input int k, input logic st, input logic wd);
    if (!st && !wd) return 2'b00;
    if (st && !wd)  return (k == 0) ? 2'b00 : 2'b10;
    if (!st && wd)  return (k == 0) ? 2'b00 : 2'b01;
    case (k)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  // one byte handshake: acknowledge plus strobe held for one clock edge
  task automatic pulse(input logic use_b, input logic is_rd);
    if (use_b) ack_b = 1'b1; else ack_a = 1'b1;
    if (is_rd) rd_stb = 1'b1; else wr_stb = 1'b1;
    @(negedge clk);
    ack_a = 1'b0; ack_b = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0;
  endtask

  // full sample on one path; scramble flips the format after the start (R11)
  task automatic run_sample(input logic cap, input logic st, input logic wd,
                            input logic scramble, input string tag);
    logic on_b;
    int n;
    on_b = cap && !single_chan;
    n = nbytes(st, wd);
    fmt_stereo = st; fmt_wide = wd;
    if (cap) cap_need = 1'b1; else play_need = 1'b1;
    @(negedge clk);
    play_need = 1'b0; cap_need = 1'b0;
    chk({tag, " R8 req rises"}, on_b ? req_b : req_a, 1);
    chk({tag, " R7 first lane"}, cap ? cap_lane : play_lane, exp_lane(0, st, wd));
    if (scramble) begin
      fmt_stereo = ~st; fmt_wide = ~wd;
    end
    for (int k = 0; k < n; k++) begin
      pulse(on_b, cap);
      if (k < n - 1) begin
        chk({tag, " R8 req held"}, on_b ? req_b : req_a, 1);
        chk({tag, " R7 lane order"}, cap ? cap_lane : play_lane, exp_lane(k + 1, st, wd));
        chk({tag, " R6 no early done"}, cap ? cap_done : play_done, 0);
      end else begin
        chk({tag, " R10 done pulse"}, cap ? cap_done : play_done, 1);
        chk({tag, " R9 req drops"}, on_b ? req_b : req_a, 0);
      end
    end
    @(negedge clk);
    chk({tag, " R10 done one cycle"}, cap ? cap_done : play_done, 0);
    chk({tag, " R9 gap"}, on_b ? req_b : req_a, 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 req_a", req_a, 0);
    chk("R1 req_b", req_b, 0);
    chk("R1 dones", {play_done, cap_done}, 0);
    chk("R1 lanes", {play_lane, cap_lane}, 0);
  endtask

  task automatic t_formats_dual();
    single_chan = 1'b0; play_en = 1'b1; cap_en = 1'b1;
    for (int f = 0; f < 4; f++) begin
      run_sample(1'b0, f[0], f[1], 1'b0, "R2 R6 play dual");
      run_sample(1'b1, f[0], f[1], 1'b0, "R2 R6 cap dual");
    end
  endtask

  task automatic t_concurrent();
    single_chan = 1'b0; play_en = 1'b1; cap_en = 1'b1;
    fmt_stereo = 1'b0; fmt_wide = 1'b0;
    play_need = 1'b1; cap_need = 1'b1;
    @(negedge clk);
    play_need = 1'b0; cap_need = 1'b0;
    chk("R2 both requests", {req_a, req_b}, 2'b11);
    ack_a = 1'b1; wr_stb = 1'b1; ack_b = 1'b1; rd_stb = 1'b1;
    @(negedge clk);
    ack_a = 1'b0; wr_stb = 1'b0; ack_b = 1'b0; rd_stb = 1'b0;
    chk("R2 both done", {play_done, cap_done}, 2'b11);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_stray();
    single_chan = 1'b0; play_en = 1'b1;
    fmt_stereo = 1'b0; fmt_wide = 1'b1;
    play_need = 1'b1;
    @(negedge clk);
    play_need = 1'b0;
    ack_a = 1'b1;
    repeat (2) @(negedge clk);
    ack_a = 1'b0; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; ack_a = 1'b1; rd_stb = 1'b1;
    @(negedge clk);
    ack_a = 1'b0; rd_stb = 1'b0;
    chk("R8 stray lane", play_lane, 2'b00);
    chk("R8 stray req", req_a, 1);
    chk("R8 stray done", play_done, 0);
    pulse(1'b0, 1'b0);
    chk("R8 lane after real", play_lane, 2'b01);
    pulse(1'b0, 1'b0);
    chk("R8 completes", play_done, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_latch();
    single_chan = 1'b0; play_en = 1'b1; cap_en = 1'b1;
    run_sample(1'b0, 1'b1, 1'b1, 1'b1, "R11 play 16s scrambled");
    run_sample(1'b1, 1'b0, 1'b1, 1'b1, "R11 cap 16m scrambled");
  endtask

  task automatic t_enable();
    single_chan = 1'b0; play_en = 1'b0;
    fmt_stereo = 1'b1; fmt_wide = 1'b0;
    play_need = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 disabled no req", req_a, 0);
    play_en = 1'b1;
    @(negedge clk);
    play_need = 1'b0;
    chk("R5 enabled req", req_a, 1);
    play_en = 1'b0;
    pulse(1'b0, 1'b0);
    chk("R5 continues after disable", req_a, 1);
    pulse(1'b0, 1'b0);
    chk("R5 finishes after disable", play_done, 1);
    repeat (2) @(negedge clk);
    play_en = 1'b1;
  endtask

  task automatic t_shared();
    single_chan = 1'b1; play_en = 1'b0; cap_en = 1'b1;
    fmt_stereo = 1'b0; fmt_wide = 1'b1;
    cap_need = 1'b1;
    @(negedge clk);
    cap_need = 1'b0;
    chk("R3 cap on req_a", {req_a, req_b}, 2'b10);
    ack_b = 1'b1; rd_stb = 1'b1;
    @(negedge clk);
    ack_b = 1'b0; rd_stb = 1'b0;
    chk("R3 ack_b ignored lane", cap_lane, 2'b00);
    chk("R3 ack_b ignored req", req_a, 1);
    pulse(1'b0, 1'b1);
    chk("R3 ack_a advances", cap_lane, 2'b01);
    pulse(1'b0, 1'b1);
    chk("R3 shared cap done", {cap_done, play_done}, 2'b10);
    repeat (2) @(negedge clk);
    play_en = 1'b1; cap_en = 1'b0;
    run_sample(1'b0, 1'b1, 1'b0, 1'b0, "R3 R5 shared switch to play");
  endtask

  task automatic t_priority();
    single_chan = 1'b1; play_en = 1'b1; cap_en = 1'b1;
    fmt_stereo = 1'b0; fmt_wide = 1'b0;
    play_need = 1'b1; cap_need = 1'b1;
    @(negedge clk);
    play_need = 1'b0;
    chk("R4 req_a raised", req_a, 1);
    pulse(1'b0, 1'b1);
    chk("R4 read strobe no effect on play", play_done, 0);
    pulse(1'b0, 1'b0);
    chk("R4 playback first", {play_done, cap_done}, 2'b10);
    @(negedge clk);
    chk("R4 R9 gap before capture", req_a, 0);
    @(negedge clk);
    cap_need = 1'b0;
    chk("R4 capture follows", req_a, 1);
    pulse(1'b0, 1'b1);
    chk("R4 capture done", {play_done, cap_done}, 2'b01);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_formats_dual();
    t_concurrent();
    t_stray();
    t_latch();
    t_enable();
    t_shared();
    t_priority();
    finish_run();
  end

endmodule